// File: doc/BRIEF.md
# Primary Interrupt Pending Controller

This block collects up to 32 interrupt sources into one request line for a processor. Each source latches into a source-pending register. Edge sources latch on a rising edge and level sources latch in every cycle their input is high. A per-bit mask selects which pending sources may take part. An interrupt-pending register holds the single request being serviced, and it drives the processor request output.

Software reaches the block through a simple synchronous register port. The port has an address, a write strobe, write data and combinational read data. Both pending registers clear bits when ones are written to them. A source is acknowledged by writing its one-hot value first to source-pending and then to interrupt-pending. The ack has this order so that the interrupt-pending register does not reload the same request.

Two source positions are reserved and never latch. Positions 4 and 5 carry combined requests from a secondary external-pin controller, so they are level sensitive by default. A separate wake mask for sleep mode sits beside the interrupt mask. Software may clear a wake-mask bit only where a fixed allow vector permits it.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, source-pending and interrupt-pending read 0, the interrupt mask and the wake mask read all ones, and `irq_o` is 0.
- R2: An edge-mode source sets its source-pending bit when its input is 1 at a clock edge after being 0 at the previous edge. A held-high edge input sets the bit only once. A set bit stays set until software clears it, whatever its mask bit is.
- R3: Writing address 0 (source-pending) clears every bit written as 1 and leaves bits written as 0 unchanged. If a source sets in the same cycle that its bit is cleared, the set wins.
- R4: Address 1 is the interrupt mask, and it reads back what was written. A mask bit of 1 keeps its pending source out of interrupt-pending, and a bit of 0 lets the source through.
- R5: Interrupt-pending (address 2) holds at most one bit. When it is empty, the next clock edge loads it with the lowest-numbered source that is both pending and unmasked. While it is non-empty, it holds its value even if a lower-numbered source becomes pending.
- R6: Writing address 2 clears the interrupt-pending bits written as 1. Bits written as 0 are left unchanged.
- R7: `irq_o` is 1 exactly when interrupt-pending is non-zero.
- R8: Source positions 6 and 24 never become pending, and never reach interrupt-pending, whatever their input does.
- R9: The wake mask is at address 3 and drives `wake_mask_o`. A write can clear only the bits set in the allow vector, and all other bits stay 1. By default the allow vector is bits 0 to 3 plus bit 30, the real-time-clock position.
- R10: Positions 4 and 5 are level sensitive by default. While their input is high, the pending bit is set again in every cycle, so a clear written during that time does not stick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Raw interrupt source inputs |
| reg_addr | input | 3 | Register address: 0 source-pending, 1 mask, 2 interrupt-pending, 3 wake mask |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the addressed register (0 for unused addresses) |
| irq_o | output | 1 | Interrupt request to the processor |
| wake_mask_o | output | 32 | Wake mask for sleep mode, 1 means not a wake source |

## Verification
A source event seen at clock edge k appears in source-pending right after edge k. It reaches interrupt-pending and `irq_o` right after edge k+1. A register write takes effect at the edge where the strobe is sampled. Read data follows the address within the same cycle. The bench drives inputs on the falling edge and reads results just after a later falling edge. It counts one or two rising edges before each check, as these latencies require, so every expected value is sampled in its own cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  parameter int IRQC_AW = 3;

  typedef enum logic [IRQC_AW-1:0] {
    REG_SRCPEND = 3'd0,
    REG_MASK    = 3'd1,
    REG_INTPEND = 3'd2,
    REG_WAKE    = 3'd3
  } irqc_reg_e;

endpackage

// File: rtl/irqc_src_latch.sv
module irqc_src_latch #(
  parameter int             N         = 32,
  parameter logic [N-1:0]   LEVEL_MAP = '0,
  parameter logic [N-1:0]   RSVD_MAP  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] set_o
);

  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] edge_w;
  logic [N-1:0] set_w;

  // Rising edge relative to the previous sample; level bits follow the pin.
  assign edge_w = src_i & ~prev_q;
  assign set_w  = ((src_i & LEVEL_MAP) | (edge_w & ~LEVEL_MAP)) & ~RSVD_MAP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= src_i;
      pend_q <= ((pend_q & ~clr_i) | set_w) & ~RSVD_MAP;
    end
  end

  assign pend_o = pend_q;
  assign set_o  = set_w;

  AST_SRC_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((pend_o & $past(clr_i & ~set_o)) == '0)); // R3

  AST_SRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_o & ~clr_i) & ~pend_o) == '0)); // R2

  AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_i & RSVD_MAP) != '0) |=> ((pend_o & RSVD_MAP) == '0)); // R8

endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] int_pend_o,
  output logic         load_o
);

  // Isolate the lowest set bit of a vector.
  function automatic logic [N-1:0] pick_lowest(input logic [N-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  logic [N-1:0] cand_w;
  logic [N-1:0] int_q;
  logic         empty_w;

  assign cand_w  = pend_i & ~mask_i;
  assign empty_w = (int_q == '0);
  assign load_o  = empty_w && (cand_w != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q <= '0;
    end else if (empty_w) begin
      int_q <= pick_lowest(cand_w);
    end else begin
      int_q <= int_q & ~clr_i;
    end
  end

  assign int_pend_o = int_q;

  AST_INT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(int_pend_o)); // R5

  AST_INT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|int_pend_o) |-> (((int_pend_o & $past(cand_w)) != '0) &&
                            (((int_pend_o - 1'b1) & $past(cand_w)) == '0))); // R5

  AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_pend_o != '0) && (clr_i == '0)) |=> $stable(int_pend_o)); // R5

  AST_INT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_pend_o != '0) && ((int_pend_o & clr_i) == int_pend_o)) |=> (int_pend_o == '0)); // R6

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int           N     = 32,
  parameter logic [N-1:0] ALLOW = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_mask_i,
  input  logic         wr_wake_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] wake_o
);

  logic [N-1:0] mask_q;
  logic [N-1:0] wake_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      wake_q <= '1;
    end else begin
      if (wr_mask_i) mask_q <= wdata_i;
      if (wr_wake_i) wake_q <= wdata_i | ~ALLOW;
    end
  end

  assign mask_o = mask_q;
  assign wake_o = wake_q;

  AST_WAKE_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((~wake_o & ~ALLOW) == '0)); // R9

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_i |=> (mask_o == $past(wdata_i))); // R4

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int           N         = 32,
  parameter int           RSVD_A    = 6,
  parameter int           RSVD_B    = 24,
  parameter int           WAKE_PINS = 4,
  parameter int           RTC_POS   = 30,
  parameter logic [N-1:0] LEVEL_MAP = 32'h0000_0030
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N-1:0]               src_in,
  input  logic [irqc_pkg::IRQC_AW-1:0] reg_addr,
  input  logic                       reg_wr,
  input  logic [N-1:0]               reg_wdata,
  output logic [N-1:0]               reg_rdata,
  output logic                       irq_o,
  output logic [N-1:0]               wake_mask_o
);
  import irqc_pkg::*;

  localparam logic [N-1:0] RSVD_MAP = (N'(1) << RSVD_A) | (N'(1) << RSVD_B);
  localparam logic [N-1:0] ALLOW    = ((N'(1) << WAKE_PINS) - N'(1)) | (N'(1) << RTC_POS);

  logic [N-1:0] src_clr_w, int_clr_w;
  logic         wr_mask_w, wr_wake_w;
  logic [N-1:0] src_pend_w, src_set_w, mask_w, int_pend_w, wake_w;
  logic         load_w;

  assign src_clr_w = (reg_wr && reg_addr == REG_SRCPEND) ? reg_wdata : '0;
  assign int_clr_w = (reg_wr && reg_addr == REG_INTPEND) ? reg_wdata : '0;
  assign wr_mask_w = reg_wr && (reg_addr == REG_MASK);
  assign wr_wake_w = reg_wr && (reg_addr == REG_WAKE);

  irqc_src_latch #(.N(N), .LEVEL_MAP(LEVEL_MAP), .RSVD_MAP(RSVD_MAP)) u_src (
    .clk(clk), .rst_n(rst_n), .src_i(src_in), .clr_i(src_clr_w),
    .pend_o(src_pend_w), .set_o(src_set_w)
  );

  irqc_regs #(.N(N), .ALLOW(ALLOW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_mask_i(wr_mask_w), .wr_wake_i(wr_wake_w),
    .wdata_i(reg_wdata), .mask_o(mask_w), .wake_o(wake_w)
  );

  irqc_select #(.N(N)) u_sel (
    .clk(clk), .rst_n(rst_n), .pend_i(src_pend_w), .mask_i(mask_w),
    .clr_i(int_clr_w), .int_pend_o(int_pend_w), .load_o(load_w)
  );

  always_comb begin
    case (reg_addr)
      REG_SRCPEND: reg_rdata = src_pend_w;
      REG_MASK:    reg_rdata = mask_w;
      REG_INTPEND: reg_rdata = int_pend_w;
      REG_WAKE:    reg_rdata = wake_w;
      default:     reg_rdata = '0;
    endcase
  end

  assign irq_o       = |int_pend_w;
  assign wake_mask_o = wake_w;

  AST_SET_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set_w != '0) |=> ((src_pend_w & $past(src_set_w)) == $past(src_set_w))); // R2

  AST_LOAD_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> irq_o); // R7

endmodule

// File: tb/tb_irq_pend_ctrl.sv
module tb_irq_pend_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  logic [31:0] wake_mask_o;

  int tests = 0;
  int failed = 0;

  localparam logic [31:0] ALLOW_EXP = 32'h4000_000F;

  irq_pend_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .wake_mask_o(wake_mask_o)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int i);
    src_in[i] = 1'b1;
    step();
    src_in[i] = 1'b0;
  endtask

  task automatic clear_all();
    wr(3'd1, '1);
    wr(3'd0, '1);
    wr(3'd2, '1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; failed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] bit_i;
    logic [31:0] exp_pend;
    repeat (3) step();
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); check("R1 srcpend", v, 32'h0);
    rd(3'd1, v); check("R1 mask", v, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R1 intpend", v, 32'h0);
    rd(3'd3, v); check("R1 wake", v, 32'hFFFF_FFFF);
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    // R4 masked source stays out, unmasking lets it through
    pulse(10); step();
    rd(3'd0, v); check("R4 masked srcpend", v, 32'h400);
    rd(3'd2, v); check("R4 masked intpend", v, 32'h0);
    check("R4 masked irq", {31'b0, irq_o}, 32'h0);
    wr(3'd1, ~32'h400);
    rd(3'd1, v); check("R4 mask readback", v, ~32'h400);
    rd(3'd2, v); check("R4 intpend before load", v, 32'h0);
    step();
    rd(3'd2, v); check("R4 unmasked intpend", v, 32'h400);
    check("R7 irq high", {31'b0, irq_o}, 32'h1);
    clear_all();
    check("R7 irq low", {31'b0, irq_o}, 32'h0);

    // R5 priority and hold, R6 ack order
    wr(3'd1, 32'h0);
    src_in = 32'h0010_1008; step(); src_in = '0;
    step();
    rd(3'd2, v); check("R5 lowest wins", v, 32'h8);
    wr(3'd0, 32'h8);
    wr(3'd2, 32'h8);
    rd(3'd2, v); check("R6 intpend cleared", v, 32'h0);
    step();
    rd(3'd2, v); check("R5 next lowest", v, 32'h1000);
    pulse(1); step();
    rd(3'd2, v); check("R5 hold despite lower", v, 32'h1000);
    rd(3'd0, v); check("R2 srcpend accumulate", v, 32'h0010_1002);
    wr(3'd2, 32'h0);
    rd(3'd2, v); check("R6 zero write keeps", v, 32'h1000);
    clear_all();
    rd(3'd2, v); check("R6 cleanup intpend", v, 32'h0);

    // R3 write-one-to-clear on source-pending
    pulse(9);
    wr(3'd0, 32'h0);
    rd(3'd0, v); check("R3 zero write keeps", v, 32'h200);
    wr(3'd0, ~32'h200);
    rd(3'd0, v); check("R3 other ones keep", v, 32'h200);
    wr(3'd0, 32'h200);
    rd(3'd0, v); check("R3 clear", v, 32'h0);
    src_in[15] = 1'b1;
    wr(3'd0, 32'h8000);
    src_in[15] = 1'b0;
    rd(3'd0, v); check("R3 set wins", v, 32'h8000);
    wr(3'd0, 32'h8000);

    // R10 level bit 4 vs R2 edge bit 7 held high
    src_in[4] = 1'b1; src_in[7] = 1'b1;
    step(); step();
    wr(3'd0, 32'h90);
    rd(3'd0, v); check("R10 level re-sets, R2 edge once", v, 32'h10);
    src_in[4] = 1'b0;
    wr(3'd0, 32'h10);
    rd(3'd0, v); check("R10 level cleared after drop", v, 32'h0);
    src_in[7] = 1'b0;

    // R8 reserved inputs held high
    src_in[6] = 1'b1; src_in[24] = 1'b1; wr(3'd1, 32'h0);
    step(); step();
    rd(3'd0, v); check("R8 reserved srcpend", v, 32'h0);
    rd(3'd2, v); check("R8 reserved intpend", v, 32'h0);
    src_in = '0;
    clear_all();

    // R9 wake mask
    wr(3'd3, 32'h0);
    rd(3'd3, v); check("R9 wake all-zero write", v, ~ALLOW_EXP);
    check("R9 wake port", wake_mask_o, ~ALLOW_EXP);
    wr(3'd3, 32'h0000_FFFF);
    check("R9 wake upper clear", wake_mask_o, 32'hBFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFE);
    check("R9 wake bit0", wake_mask_o, 32'hFFFF_FFFE);
    wr(3'd3, '1);
    check("R9 wake restore", wake_mask_o, 32'hFFFF_FFFF);
    rd(3'd5, v); check("R4 unused address", v, 32'h0);

    // Sweep every position: R2 R5 R7 R8 R3 R6
    for (int i = 0; i < 32; i++) begin
      bit_i = 32'h1 << i;
      exp_pend = (i == 6 || i == 24) ? 32'h0 : bit_i;
      wr(3'd1, ~bit_i);
      pulse(i); step();
      rd(3'd0, v); check($sformatf("R2/R8 sweep src %0d", i), v, exp_pend);
      rd(3'd2, v); check($sformatf("R5 sweep int %0d", i), v, exp_pend);
      check($sformatf("R7 sweep irq %0d", i), {31'b0, irq_o}, {31'b0, exp_pend != 0});
      wr(3'd0, bit_i);
      wr(3'd2, bit_i);
      step();
      rd(3'd0, v); check($sformatf("R3 sweep ack %0d", i), v, 32'h0);
      rd(3'd2, v); check($sformatf("R6 sweep ack %0d", i), v, 32'h0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule